// File: doc/BRIEF.md
# Lockstep Comparator with Silent Debug Mode

This block sits between two CPUs that run the same program in lockstep. Every cycle it compares the output bus of the primary CPU with that of the shadow CPU. It also watches a response deadline that software must keep acknowledging. When either check fails, it raises a sticky alarm. A per-alarm routing bit sends each alarm to either a minor-severity or a major-severity output for the system supervisor. On the first compare failure it captures the differing bit positions. A saturating statistics counter counts every failure event.

A 4-bit debug key puts the block into a silent state, used while software on the primary CPU is being debugged. In that state, real compare mismatches and real deadline expiries raise nothing. Software can still inject faults. A root injection enters at the comparator or at the timeout and travels the whole path, including context capture and the statistics counter. An alarm injection forces an alarm bit directly. The deadline state machine keeps running whatever the key says. Its states are T_IDLE, T_RUN and T_EXPIRED, with these transitions:

- any state to T_IDLE whenever the deadline is zero
- T_IDLE to T_RUN when the deadline is nonzero, loading the counter
- T_RUN to T_RUN with a reload when an acknowledge arrives
- T_RUN to T_EXPIRED when the counter reads zero with no acknowledge
- T_EXPIRED to T_RUN on an acknowledge, reloading the counter

Top module: `lockstep_monitor`

## Requirements
- R1: The block is silent exactly while `silent_key` equals 4'hA. Any other value means normal operation, and the `silent` output reports the state.
- R2: In normal mode, with `cmp_en` high, a cycle in which `pri_bus` differs from `shd_bus` sets `alarm[0]` at the next clock edge. With `cmp_en` low, differences are ignored.
- R3: In silent mode a real bus mismatch changes neither `alarm[0]`, `mismatch_ctx` nor `stat_cnt`.
- R4: A `root_inj_cmp` pulse acts as a compare failure in either mode. It sets `alarm[0]`, counts once, and contributes bit 0 to the captured difference pattern. In normal mode, any live difference in the same cycle is ORed into that pattern.
- R5: With a nonzero `deadline` D and no acknowledge, `alarm[1]` rises D+2 edges after the deadline first becomes nonzero (one edge to load, then D+1 edges of counting). A `tmo_ack` pulse reloads the counter to D.
- R6: In silent mode an expiry raises no alarm, and leaving silent mode afterwards raises none either. A `root_inj_tmo` pulse sets `alarm[1]` and counts once in either mode.
- R7: An `alarm_inj[i]` pulse sets `alarm[i]` in both modes. It leaves `stat_cnt` and `mismatch_ctx` unchanged.
- R8: Alarms stay set until a write-one-to-clear pulse on `alarm_clr[i]`. If set and clear arrive in the same cycle, the set wins.
- R9: `alarm[0]` is the compare alarm and `alarm[1]` is the timeout alarm. `route[i]`=1 sends alarm i to `sev_major`, and 0 sends it to `sev_minor`. The routing takes effect at once, in any mode.
- R10: `mismatch_ctx` captures the difference pattern of the first compare event while it holds zero, then stays unchanged. `alarm_clr[0]` resets it to zero, or to the pattern of a compare event in that same cycle.
- R11: `stat_cnt` adds one for each compare event and one for each timeout event in a cycle, and saturates at its all-ones value.
- R12: A zero `deadline` holds the timer in T_IDLE with no expiry. An acknowledge in T_EXPIRED restarts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| silent_key | input | 4 | Debug key; 4'hA selects silent mode |
| cmp_en | input | 1 | Enables the bus compare |
| pri_bus | input | W | Primary CPU output bus |
| shd_bus | input | W | Shadow CPU output bus |
| deadline | input | CW | Timeout reload value; zero disables the timer |
| tmo_ack | input | 1 | Acknowledge pulse that reloads the timer |
| root_inj_cmp | input | 1 | Root fault injection pulse at the comparator |
| root_inj_tmo | input | 1 | Root fault injection pulse at the timer |
| alarm_inj | input | 2 | Direct alarm injection pulses |
| alarm_clr | input | 2 | Write-one-to-clear pulses for the alarms |
| route | input | 2 | Per-alarm severity select |
| alarm | output | 2 | Sticky alarms: bit 0 compare, bit 1 timeout |
| sev_minor | output | 1 | OR of alarms routed to minor severity |
| sev_major | output | 1 | OR of alarms routed to major severity |
| mismatch_ctx | output | W | Captured difference pattern |
| stat_cnt | output | SW | Saturating failure-event counter |
| silent | output | 1 | High while silent mode is active |

## Verification
The compare path is driven with several patterns:

- single-bit and multi-bit differences, which tell first-capture context apart from later events
- differences with `cmp_en` low
- the same differences under the silent key, which separates a real mismatch from an injected one

The timer is run three ways: left free, kept alive by periodic acknowledges, and disabled with a zero deadline. Its expiry edge is checked one cycle early and on time. Expiries in silent mode confirm that no alarm leaks out later. Repeated injections drive the counter into saturation, and same-cycle set and clear pulses show which one wins.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int          NUM_ALARMS = 2;
    localparam int          ALM_CMP    = 0;
    localparam int          ALM_TMO    = 1;
    localparam logic [3:0]  SILENT_KEY = 4'hA;

    typedef enum logic [1:0] {
        T_IDLE    = 2'd0,
        T_RUN     = 2'd1,
        T_EXPIRED = 2'd2
    } tmo_state_e;

endpackage

// File: rtl/lsm_cmp.sv
module lsm_cmp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         silent,
    input  logic         cmp_en,
    input  logic [W-1:0] pri_bus,
    input  logic [W-1:0] shd_bus,
    input  logic         root_inj,
    input  logic         ctx_clr,
    output logic         cmp_event,
    output logic [W-1:0] ctx
);

    logic [W-1:0] live_diff;
    logic [W-1:0] pattern;

    // real differences are only looked at when compare is live
    always_comb begin
        live_diff = (cmp_en && !silent) ? (pri_bus ^ shd_bus) : '0;
        pattern   = live_diff | {{(W-1){1'b0}}, root_inj};
        cmp_event = |pattern;
    end

    // zero context means nothing captured yet
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctx <= '0;
        else if (ctx_clr || (ctx == '0))
            ctx <= pattern;
    end

endmodule

// File: rtl/lsm_tmo.sv
module lsm_tmo
    import lsm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] deadline,
    input  logic          ack,
    input  logic          silent,
    input  logic          root_inj,
    output logic          tmo_event
);

    tmo_state_e    state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          expire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= T_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        expire    = 1'b0;
        if (deadline == '0) begin
            state_nxt = T_IDLE;
            cnt_nxt   = '0;
        end else begin
            unique case (state)
                T_IDLE: begin
                    state_nxt = T_RUN;
                    cnt_nxt   = deadline;
                end
                T_RUN: begin
                    if (ack) begin
                        cnt_nxt = deadline;
                    end else if (cnt == '0) begin
                        expire    = 1'b1;
                        state_nxt = T_EXPIRED;
                    end else begin
                        cnt_nxt = cnt - CW'(1);
                    end
                end
                T_EXPIRED: begin
                    if (ack) begin
                        state_nxt = T_RUN;
                        cnt_nxt   = deadline;
                    end
                end
                default: state_nxt = T_IDLE;
            endcase
        end
    end

    // the timer itself ignores the debug key; only its alarm is muted
    assign tmo_event = (expire && !silent) || root_inj;

endmodule

// File: rtl/lsm_alarm.sv
module lsm_alarm
    import lsm_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_ALARMS-1:0] events,
    input  logic [NUM_ALARMS-1:0] inj,
    input  logic [NUM_ALARMS-1:0] clr,
    input  logic [NUM_ALARMS-1:0] route,
    output logic [NUM_ALARMS-1:0] alarm,
    output logic                  sev_minor,
    output logic                  sev_major,
    output logic [SW-1:0]         stat
);

    logic [1:0]  inc;
    logic [SW:0] sum;

    genvar g;
    generate
        for (g = 0; g < NUM_ALARMS; g++) begin : g_latch
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    alarm[g] <= 1'b0;
                else
                    alarm[g] <= (alarm[g] & ~clr[g]) | events[g] | inj[g];
            end
        end
    endgenerate

    always_comb begin
        inc = {1'b0, events[ALM_CMP]} + {1'b0, events[ALM_TMO]};
        sum = {1'b0, stat} + {{(SW-1){1'b0}}, inc};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stat <= '0;
        else
            stat <= sum[SW] ? '1 : sum[SW-1:0];
    end

    assign sev_major = |(alarm & route);
    assign sev_minor = |(alarm & ~route);

endmodule

// File: rtl/lockstep_monitor.sv
module lockstep_monitor
    import lsm_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 8,
    parameter int SW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            silent_key,
    input  logic                  cmp_en,
    input  logic [W-1:0]          pri_bus,
    input  logic [W-1:0]          shd_bus,
    input  logic [CW-1:0]         deadline,
    input  logic                  tmo_ack,
    input  logic                  root_inj_cmp,
    input  logic                  root_inj_tmo,
    input  logic [NUM_ALARMS-1:0] alarm_inj,
    input  logic [NUM_ALARMS-1:0] alarm_clr,
    input  logic [NUM_ALARMS-1:0] route,
    output logic [NUM_ALARMS-1:0] alarm,
    output logic                  sev_minor,
    output logic                  sev_major,
    output logic [W-1:0]          mismatch_ctx,
    output logic [SW-1:0]         stat_cnt,
    output logic                  silent
);

    logic                  cmp_event;
    logic                  tmo_event;
    logic [NUM_ALARMS-1:0] events;

    assign silent = (silent_key == SILENT_KEY);

    lsm_cmp #(.W(W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .silent    (silent),
        .cmp_en    (cmp_en),
        .pri_bus   (pri_bus),
        .shd_bus   (shd_bus),
        .root_inj  (root_inj_cmp),
        .ctx_clr   (alarm_clr[ALM_CMP]),
        .cmp_event (cmp_event),
        .ctx       (mismatch_ctx)
    );

    lsm_tmo #(.CW(CW)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .deadline  (deadline),
        .ack       (tmo_ack),
        .silent    (silent),
        .root_inj  (root_inj_tmo),
        .tmo_event (tmo_event)
    );

    always_comb begin
        events          = '0;
        events[ALM_CMP] = cmp_event;
        events[ALM_TMO] = tmo_event;
    end

    lsm_alarm #(.SW(SW)) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .events    (events),
        .inj       (alarm_inj),
        .clr       (alarm_clr),
        .route     (route),
        .alarm     (alarm),
        .sev_minor (sev_minor),
        .sev_major (sev_major),
        .stat      (stat_cnt)
    );

endmodule

// File: rtl/lockstep_monitor_chk.sv
module lockstep_monitor_chk #(
    parameter int W  = 16,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          silent,
    input logic          root_inj_cmp,
    input logic          root_inj_tmo,
    input logic [1:0]    alarm_inj,
    input logic [1:0]    alarm_clr,
    input logic [1:0]    alarm,
    input logic [W-1:0]  mismatch_ctx,
    input logic [SW-1:0] stat_cnt
);

    // R3
    silent_cmp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (silent && !root_inj_cmp && !alarm_inj[0] && !alarm[0]) |=> !alarm[0]);

    // R6
    silent_tmo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (silent && !root_inj_tmo && !alarm_inj[1] && !alarm[1]) |=> !alarm[1]);

    // R4
    root_cmp_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        root_inj_cmp |=> (alarm[0] && (mismatch_ctx != '0)));

    // R7
    alarm_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_inj[1] |=> alarm[1]);

    // R8
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm[0] && !alarm_clr[0]) |=> alarm[0]);

    // R10
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mismatch_ctx != '0) && !alarm_clr[0]) |=> $stable(mismatch_ctx));

    // R11
    stat_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_cnt >= $past(stat_cnt)));

endmodule

bind lockstep_monitor lockstep_monitor_chk #(.W(W), .SW(SW)) u_chk (.*);

// File: tb/lockstep_monitor_test.sv
module lockstep_monitor_test;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int CW = 8;
    localparam int SW = 4;
    localparam int STAT_MAX = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    silent_key = '0;
    logic          cmp_en = 1'b0;
    logic [W-1:0]  pri_bus = '0;
    logic [W-1:0]  shd_bus = '0;
    logic [CW-1:0] deadline = '0;
    logic          tmo_ack = 1'b0;
    logic          root_inj_cmp = 1'b0;
    logic          root_inj_tmo = 1'b0;
    logic [1:0]    alarm_inj = '0;
    logic [1:0]    alarm_clr = '0;
    logic [1:0]    route = '0;
    logic [1:0]    alarm;
    logic          sev_minor, sev_major, silent;
    logic [W-1:0]  mismatch_ctx;
    logic [SW-1:0] stat_cnt;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    lockstep_monitor #(.W(W), .CW(CW), .SW(SW)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // behavioural reference model
    logic [1:0]   m_alarm = '0;
    logic [W-1:0] m_ctx = '0;
    int           m_stat = 0;
    int           m_st = 0;
    int           m_cnt = 0;

    always @(posedge clk) begin
        bit sil, ce, te, expd;
        logic [W-1:0] pat;
        if (!rst_n) begin
            m_alarm = '0; m_ctx = '0; m_stat = 0; m_st = 0; m_cnt = 0;
        end else begin
            sil  = (silent_key == 4'hA);
            pat  = (cmp_en && !sil) ? (pri_bus ^ shd_bus) : '0;
            if (root_inj_cmp) pat[0] = 1'b1;
            ce   = (pat != '0);
            expd = 1'b0;
            if (deadline == 0) begin
                m_st = 0; m_cnt = 0;
            end else if (m_st == 0) begin
                m_st = 1; m_cnt = int'(deadline);
            end else if (m_st == 1) begin
                if (tmo_ack) m_cnt = int'(deadline);
                else if (m_cnt == 0) begin expd = 1'b1; m_st = 2; end
                else m_cnt--;
            end else if (tmo_ack) begin
                m_st = 1; m_cnt = int'(deadline);
            end
            te = (expd && !sil) || root_inj_tmo;
            m_stat = m_stat + int'(ce) + int'(te);
            if (m_stat > STAT_MAX) m_stat = STAT_MAX;
            if (alarm_clr[0] || m_ctx == '0) m_ctx = pat;
            m_alarm = (m_alarm & ~alarm_clr) | {te, ce} | alarm_inj;
        end
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            chk("R8 alarm vs model", 32'(alarm), 32'(m_alarm));
            chk("R10 ctx vs model", 32'(mismatch_ctx), 32'(m_ctx));
            chk("R11 stat vs model", 32'(stat_cnt), 32'(m_stat));
            chk("R9 sev_major vs model", 32'(sev_major), 32'(|(m_alarm & route)));
            chk("R9 sev_minor vs model", 32'(sev_minor), 32'(|(m_alarm & ~route)));
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog act=%0d exp<%0d cycles", 50000, 50000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("reset alarm", 32'(alarm), 0);
        chk("reset ctx", 32'(mismatch_ctx), 0);
        chk("reset stat", 32'(stat_cnt), 0);
        chk("R1 key 0", 32'(silent), 0);
        silent_key = 4'h5; #1;
        chk("R1 key 5", 32'(silent), 0);
        silent_key = 4'hA; #1;
        chk("R1 key A", 32'(silent), 1);
        silent_key = 4'h0;
        tick();

        // normal compare
        cmp_en = 1'b1; pri_bus = 16'h1234; shd_bus = 16'h1224;
        tick();
        shd_bus = pri_bus;
        chk("R2 mismatch alarm", 32'(alarm[0]), 1);
        chk("R10 first ctx", 32'(mismatch_ctx), 32'h0010);
        chk("R11 stat one", 32'(stat_cnt), 1);
        chk("R9 minor route", 32'({sev_major, sev_minor}), 32'b01);
        route = 2'b01; #1;
        chk("R9 major route", 32'({sev_major, sev_minor}), 32'b10);
        tick();
        pri_bus = 16'h00FF; shd_bus = 16'h00F0;
        tick();
        shd_bus = pri_bus;
        chk("R10 ctx kept", 32'(mismatch_ctx), 32'h0010);
        chk("R11 stat two", 32'(stat_cnt), 2);
        cmp_en = 1'b0; pri_bus = 16'hFFFF; shd_bus = 16'h0000;
        tick(); tick();
        chk("R2 disabled compare", 32'(stat_cnt), 2);
        shd_bus = pri_bus; cmp_en = 1'b1;
        alarm_clr = 2'b01;
        tick();
        alarm_clr = 2'b00;
        chk("R8 clear alarm", 32'(alarm[0]), 0);
        chk("R10 clear ctx", 32'(mismatch_ctx), 0);

        // silent compare and root injection
        silent_key = 4'hA; pri_bus = 16'hAAAA; shd_bus = 16'h5555;
        tick(); tick();
        chk("R3 silent alarm", 32'(alarm[0]), 0);
        chk("R3 silent stat", 32'(stat_cnt), 2);
        chk("R3 silent ctx", 32'(mismatch_ctx), 0);
        root_inj_cmp = 1'b1;
        tick();
        root_inj_cmp = 1'b0;
        chk("R4 root alarm", 32'(alarm[0]), 1);
        chk("R4 root ctx", 32'(mismatch_ctx), 32'h0001);
        chk("R4 root stat", 32'(stat_cnt), 3);
        route = 2'b00; #1;
        chk("R9 route in silent", 32'({sev_major, sev_minor}), 32'b01);
        shd_bus = pri_bus;
        tick();
        alarm_inj = 2'b10;
        tick();
        alarm_inj = 2'b00;
        chk("R7 silent force", 32'(alarm[1]), 1);
        chk("R7 no stat", 32'(stat_cnt), 3);
        alarm_clr = 2'b11;
        tick();
        alarm_clr = 2'b00;
        chk("R8 clear both", 32'(alarm), 0);
        silent_key = 4'h0;
        alarm_inj = 2'b01;
        tick();
        alarm_inj = 2'b00;
        chk("R7 normal force", 32'(alarm[0]), 1);
        chk("R7 no ctx", 32'(mismatch_ctx), 0);
        alarm_inj = 2'b01; alarm_clr = 2'b01;
        tick();
        chk("R8 set wins", 32'(alarm[0]), 1);
        alarm_inj = 2'b00;
        tick();
        alarm_clr = 2'b00;
        chk("R8 cleared", 32'(alarm[0]), 0);

        // timeout, normal mode
        deadline = 8'd5;
        for (int i = 0; i < 6; i++) tick();
        chk("R5 not yet expired", 32'(alarm[1]), 0);
        tick();
        chk("R5 expired", 32'(alarm[1]), 1);
        chk("R11 timeout counted", 32'(stat_cnt), 4);
        tmo_ack = 1'b1; alarm_clr = 2'b10;
        tick();
        tmo_ack = 1'b0; alarm_clr = 2'b00;
        for (int i = 0; i < 8; i++) begin
            tick(); tick();
            tmo_ack = 1'b1;
            tick();
            tmo_ack = 1'b0;
        end
        chk("R5 R12 kept alive", 32'(alarm[1]), 0);
        deadline = 8'd0;
        repeat (20) tick();
        chk("R12 idle no expiry", 32'(alarm[1]), 0);

        // timeout, silent mode
        silent_key = 4'hA; deadline = 8'd3;
        repeat (12) tick();
        chk("R6 silent expiry", 32'(alarm[1]), 0);
        chk("R6 silent stat", 32'(stat_cnt), 4);
        silent_key = 4'h0;
        repeat (5) tick();
        chk("R6 after exit", 32'(alarm[1]), 0);
        deadline = 8'd0; silent_key = 4'hA;
        root_inj_tmo = 1'b1;
        tick();
        root_inj_tmo = 1'b0;
        chk("R6 root timeout", 32'(alarm[1]), 1);
        chk("R6 root stat", 32'(stat_cnt), 5);
        silent_key = 4'h0;

        // saturation
        root_inj_cmp = 1'b1;
        repeat (15) tick();
        root_inj_cmp = 1'b0;
        chk("R11 saturated", 32'(stat_cnt), STAT_MAX);
        tick();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule